// File: doc/BRIEF.md
# Multi-core power and reset sequencer

This block brings a group of processor cores up and takes them down in a fixed, verified order. A host presents a command with a core mask and a direction (enable or disable). The sequencer drives a power request, a reset and a stall line for each core, and watches two per-core status lines: the power acknowledge from the power switch and the reset state that the core reports back. Each wait for a status change has a limit in clock cycles. When the command ends, the block gives a one-cycle done pulse with an error flag.

Bringing cores up means requesting power and waiting for acknowledge, then releasing reset and waiting for the cores to report that they are out of reset, then removing stall. After that, the block checks that every selected core now looks enabled. If that check fails, the cores go back to stall plus reset. Taking cores down always passes through stall plus reset first: the block waits for the reset report, then drops the power request and waits for the acknowledge to clear. The requested mask is first reduced to the cores that the host is allowed to manage. The block can therefore sit behind a simple register-mapped command port.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, pwr_req is all 0, core_rst and core_stall are all 1, and busy and done are 0.
- R2: Only the bits of cmd_mask that are also set in the parameter HOST_MASK are acted on. A command whose filtered mask is zero completes with done and err=0 in the cycle after it is taken, and changes no output.
- R3: A set of cores counts as enabled only when pwr_req and pwr_ack are 1 and rst_ack and core_stall are 0 for every selected core. An enable command whose selected cores are already enabled completes with err=0 in the cycle after it is taken, without touching the outputs.
- R4: Enable order is fixed. pwr_req is raised first. core_rst is released only after pwr_ack reads 1 for all selected cores. core_stall is cleared only after rst_ack reads 0 for all selected cores.
- R5: A successful enable ends with err=0 and with pwr_req=1, core_rst=0 and core_stall=0 for every selected core.
- R6: If pwr_ack has not reached 1 for all selected cores within TO_PWRUP cycles, the command ends with err=1 and core_rst stays asserted.
- R7: If rst_ack has not reached 0 within TO_RST cycles after reset release, the command ends with err=1 and core_stall stays asserted.
- R8: If the enabled check after unstall fails, core_stall and core_rst are asserted again for the selected cores and the command ends with err=1.
- R9: Disable asserts core_stall and core_rst, waits for rst_ack=1 on all selected cores, then drops pwr_req and waits for pwr_ack=0. A success leaves pwr_req=0, core_rst=1 and core_stall=1 for those cores, with err=0.
- R10: The power-down wait is bounded by TO_PWRDN cycles, separate from and normally longer than the other limits. When it expires, the command ends with err=1.
- R11: busy is 1 from the cycle after a command is taken until done. Commands presented while busy is 1 are ignored. done is a single-cycle pulse and is never high together with busy.
- R12: Outputs of cores that are not selected by the filtered mask never change during a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is 0 |
| cmd_enable | input | 1 | 1 = bring cores up, 0 = take them down |
| cmd_mask | input | NCORES | Cores the command addresses |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid while done is 1 |
| pwr_req | output | NCORES | Per-core power request |
| core_rst | output | NCORES | Per-core reset, 1 = held in reset |
| core_stall | output | NCORES | Per-core stall, 1 = stalled |
| pwr_ack | input | NCORES | Per-core power acknowledge |
| rst_ack | input | NCORES | Per-core reset state reported by the core |

## Verification
The bench builds the block with four cores and HOST_MASK=4'b0111, so core 3 lies outside the managed set. This makes mask filtering and the untouched-core rule visible at the ports. The timeouts are set to 8, 6 and 24 cycles. With limits this short, each timeout can be forced to expire within a few dozen cycles by a fault in the bench's core model, and the longer power-down limit can be told apart from the others by elapsed cycle count. The core model also has a fault that reasserts the reported reset once stall is removed, which drives the post-unstall check down its rollback path.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PWRUP  = 3'd1,
    ST_RSTREL = 3'd2,
    ST_CHKUP  = 3'd3,
    ST_RSTSET = 3'd4,
    ST_PWRDN  = 3'd5,
    ST_CHKDN  = 3'd6
  } seq_state_t;

endpackage

// File: rtl/cps_mask_filter.sv
module cps_mask_filter #(
  parameter int NCORES = 4,
  parameter logic [NCORES-1:0] HOST_MASK = '1
) (
  input  logic [NCORES-1:0] raw_mask,
  output logic [NCORES-1:0] eff_mask,
  output logic              eff_empty
);
  always_comb begin
    eff_mask  = raw_mask & HOST_MASK;
    eff_empty = (eff_mask == '0);
  end
endmodule

// File: rtl/cps_core_status.sv
module cps_core_status #(
  parameter int NCORES = 4
) (
  input  logic [NCORES-1:0] sel,
  input  logic [NCORES-1:0] pwr_req,
  input  logic [NCORES-1:0] pwr_ack,
  input  logic [NCORES-1:0] rst_ack,
  input  logic [NCORES-1:0] stall,
  output logic              all_on,
  output logic              ack_all,
  output logic              ack_none,
  output logic              rst_all,
  output logic              rst_none
);
  always_comb begin
    ack_all  = ((pwr_ack & sel) == sel);
    ack_none = ((pwr_ack & sel) == '0);
    rst_all  = ((rst_ack & sel) == sel);
    rst_none = ((rst_ack & sel) == '0);
    all_on   = ((pwr_req & pwr_ack & sel) == sel) &&
               (((rst_ack | stall) & sel) == '0);
  end
endmodule

// File: rtl/cps_wait_timer.sv
module cps_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb expired = (cnt_q >= (limit - 1'b1));
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import cps_pkg::*;
#(
  parameter int NCORES = 4,
  parameter logic [NCORES-1:0] HOST_MASK = '1,
  parameter int TO_PWRUP = 64,
  parameter int TO_RST   = 64,
  parameter int TO_PWRDN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_enable,
  input  logic [NCORES-1:0] cmd_mask,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [NCORES-1:0] pwr_req,
  output logic [NCORES-1:0] core_rst,
  output logic [NCORES-1:0] core_stall,
  input  logic [NCORES-1:0] pwr_ack,
  input  logic [NCORES-1:0] rst_ack
);
  localparam int TO_MAX = (TO_PWRDN > TO_PWRUP) ?
                          ((TO_PWRDN > TO_RST) ? TO_PWRDN : TO_RST) :
                          ((TO_PWRUP > TO_RST) ? TO_PWRUP : TO_RST);
  localparam int CW = $clog2(TO_MAX + 1) + 1;

  seq_state_t state_q, state_d;
  logic [NCORES-1:0] sel_q, req_q, rst_q, stl_q;
  logic done_q, err_q;

  logic [NCORES-1:0] filt_mask, eval_mask;
  logic filt_empty;
  logic all_on, ack_all, ack_none, rst_all, rst_none;
  logic tmr_restart, tmr_expired;
  logic [CW-1:0] tmr_limit;

  logic [NCORES-1:0] req_set, req_clr, rst_set, rst_clr, stl_set, stl_clr;
  logic take_sel, fin, fin_err;

  cps_mask_filter #(.NCORES(NCORES), .HOST_MASK(HOST_MASK)) u_filter (
    .raw_mask (cmd_mask),
    .eff_mask (filt_mask),
    .eff_empty(filt_empty)
  );

  always_comb eval_mask = (state_q == ST_IDLE) ? filt_mask : sel_q;

  cps_core_status #(.NCORES(NCORES)) u_status (
    .sel     (eval_mask),
    .pwr_req (req_q),
    .pwr_ack (pwr_ack),
    .rst_ack (rst_ack),
    .stall   (stl_q),
    .all_on  (all_on),
    .ack_all (ack_all),
    .ack_none(ack_none),
    .rst_all (rst_all),
    .rst_none(rst_none)
  );

  always_comb begin
    case (state_q)
      ST_PWRUP: tmr_limit = CW'(TO_PWRUP);
      ST_PWRDN: tmr_limit = CW'(TO_PWRDN);
      default:  tmr_limit = CW'(TO_RST);
    endcase
  end

  always_comb tmr_restart = (state_d != state_q);

  cps_wait_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(tmr_restart),
    .limit  (tmr_limit),
    .expired(tmr_expired)
  );

  always_comb begin
    state_d  = state_q;
    req_set  = '0; req_clr = '0;
    rst_set  = '0; rst_clr = '0;
    stl_set  = '0; stl_clr = '0;
    take_sel = 1'b0;
    fin      = 1'b0;
    fin_err  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          take_sel = 1'b1;
          if (filt_empty) begin
            fin = 1'b1;
          end else if (cmd_enable) begin
            if (all_on) begin
              fin = 1'b1;
            end else begin
              req_set = filt_mask;
              state_d = ST_PWRUP;
            end
          end else begin
            stl_set = filt_mask;
            rst_set = filt_mask;
            state_d = ST_RSTSET;
          end
        end
      end
      ST_PWRUP: begin
        if (ack_all) begin
          rst_clr = sel_q;
          state_d = ST_RSTREL;
        end else if (tmr_expired) begin
          fin = 1'b1; fin_err = 1'b1; state_d = ST_IDLE;
        end
      end
      ST_RSTREL: begin
        if (rst_none) begin
          stl_clr = sel_q;
          state_d = ST_CHKUP;
        end else if (tmr_expired) begin
          fin = 1'b1; fin_err = 1'b1; state_d = ST_IDLE;
        end
      end
      ST_CHKUP: begin
        fin     = 1'b1;
        state_d = ST_IDLE;
        if (!all_on) begin
          stl_set = sel_q;
          rst_set = sel_q;
          fin_err = 1'b1;
        end
      end
      ST_RSTSET: begin
        if (rst_all) begin
          req_clr = sel_q;
          state_d = ST_PWRDN;
        end else if (tmr_expired) begin
          fin = 1'b1; fin_err = 1'b1; state_d = ST_IDLE;
        end
      end
      ST_PWRDN: begin
        if (ack_none) begin
          state_d = ST_CHKDN;
        end else if (tmr_expired) begin
          fin = 1'b1; fin_err = 1'b1; state_d = ST_IDLE;
        end
      end
      ST_CHKDN: begin
        fin     = 1'b1;
        fin_err = all_on;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      req_q   <= '0;
      rst_q   <= '1;
      stl_q   <= '1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_sel) sel_q <= filt_mask;
      req_q  <= (req_q | req_set) & ~req_clr;
      rst_q  <= (rst_q | rst_set) & ~rst_clr;
      stl_q  <= (stl_q | stl_set) & ~stl_clr;
      done_q <= fin;
      err_q  <= fin & fin_err;
    end
  end

  always_comb begin
    busy       = (state_q != ST_IDLE);
    done       = done_q;
    err        = err_q;
    pwr_req    = req_q;
    core_rst   = rst_q;
    core_stall = stl_q;
  end
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int NCORES = 4,
  parameter logic [NCORES-1:0] HOST_MASK = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [NCORES-1:0] pwr_req,
  input logic [NCORES-1:0] core_rst,
  input logic [NCORES-1:0] core_stall,
  input logic [NCORES-1:0] pwr_ack,
  input logic [NCORES-1:0] rst_ack
);
  // Cores outside the managed set keep their reset values (R2, R12)
  assert_unmanaged_idle_R2: assert property (@(posedge clk) disable iff (rst)
    ((pwr_req & ~HOST_MASK) == '0) &&
    ((core_rst & ~HOST_MASK) == ~HOST_MASK) &&
    ((core_stall & ~HOST_MASK) == ~HOST_MASK));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_err_with_done_R11: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> (busy || done));

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    assert_rst_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(core_rst[i]) |-> $past(pwr_ack[i]) && pwr_req[i]);

    assert_unstall_after_rst_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(core_stall[i]) |-> $past(!rst_ack[i]) && !core_rst[i]);

    assert_pwr_drop_safe_R9: assert property (@(posedge clk) disable iff (rst)
      $fell(pwr_req[i]) |-> $past(rst_ack[i]) && core_stall[i] && core_rst[i]);
  end
endmodule

bind core_pwr_seq cps_checker #(.NCORES(NCORES), .HOST_MASK(HOST_MASK)) u_cps_checker (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .pwr_req   (pwr_req),
  .core_rst  (core_rst),
  .core_stall(core_stall),
  .pwr_ack   (pwr_ack),
  .rst_ack   (rst_ack)
);

// File: tb/core_pwr_seq_bench.sv
`timescale 1ns/1ps
module core_pwr_seq_bench;
  localparam int N = 4;
  localparam logic [N-1:0] HMASK = 4'b0111;
  localparam int T_UP = 8;
  localparam int T_RS = 6;
  localparam int T_DN = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_enable = 1'b0;
  logic [N-1:0] cmd_mask = '0;
  logic busy, done, err;
  logic [N-1:0] pwr_req, core_rst, core_stall, pwr_ack, rst_ack;

  logic [N-1:0] f_noack = '0, f_stuck = '0, f_rststuck = '0, f_rerst = '0;
  logic [N-1:0] p1, p2, p3, r1, r2;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  core_pwr_seq #(.NCORES(N), .HOST_MASK(HMASK), .TO_PWRUP(T_UP),
                 .TO_RST(T_RS), .TO_PWRDN(T_DN)) u_core_pwr_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_enable(cmd_enable),
    .cmd_mask(cmd_mask), .busy(busy), .done(done), .err(err),
    .pwr_req(pwr_req), .core_rst(core_rst), .core_stall(core_stall),
    .pwr_ack(pwr_ack), .rst_ack(rst_ack)
  );

  // Core and power-switch model with delays and injectable faults
  always_ff @(posedge clk) begin
    p1 <= pwr_req; p2 <= p1; p3 <= p2;
    r1 <= core_rst; r2 <= r1;
  end
  assign pwr_ack = (p3 & ~f_noack) | f_stuck;
  assign rst_ack = r2 | f_rststuck | (f_rerst & ~core_stall);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Issues one command, returns err and the cycle count to done.
  task automatic run_cmd(input bit en, input logic [N-1:0] m, input int inject,
                         output bit e, output int cyc, output bit busy1);
    bit order_ok = 1'b1;
    bit seen = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_enable = en; cmd_mask = m;
    cyc = 0; e = 1'b0; busy1 = 1'b0;
    while (!seen && cyc < 500) begin
      @(negedge clk);
      cyc++;
      cmd_valid = (cyc == inject);
      if (cyc == inject) begin cmd_enable = 1'b0; cmd_mask = '1; end
      if (cyc == 1) busy1 = busy;
      for (int i = 0; i < N; i++) begin
        if (!core_rst[i] && !pwr_ack[i]) order_ok = 1'b0;
        if (!core_stall[i] && rst_ack[i] && !f_rerst[i]) order_ok = 1'b0;
        if (!pwr_req[i] && (!core_stall[i] || !core_rst[i])) order_ok = 1'b0;
      end
      if (done) begin seen = 1'b1; e = err; end
    end
    cmd_valid = 1'b0;
    check(seen, "R11", "done reached", 32'(seen), 32'd1);
    check(order_ok, "R4/R9", "step order", 32'(order_ok), 32'd1);
    @(negedge clk);
    check(!done, "R11", "done single pulse", 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    check(pwr_req == '0, "R1", "pwr_req", 32'(pwr_req), 32'd0);
    check(core_rst == '1 && core_stall == '1, "R1", "rst/stall",
          {core_rst, core_stall}, 32'hFF);
    check(!busy && !done, "R1", "busy/done", {busy, done}, 32'd0);
  endtask

  task automatic t_filtered_empty();
    bit e, b; int c;
    run_cmd(1'b1, 4'b1000, 0, e, c, b);
    check(c == 1 && !e, "R2", "empty mask completes at once", 32'(c), 32'd1);
    check(pwr_req == '0 && core_rst == '1, "R2", "no output change",
          {pwr_req, core_rst}, 32'h0F);
  endtask

  task automatic t_enable_pair();
    bit e, b; int c;
    run_cmd(1'b1, 4'b1011, 0, e, c, b);
    check(b, "R11", "busy after take", 32'(b), 32'd1);
    check(!e, "R5", "enable err", 32'(e), 32'd0);
    check(pwr_req == 4'b0011 && core_rst == 4'b1100 && core_stall == 4'b1100,
          "R5", "cores 0,1 up", {pwr_req, core_rst, core_stall}, 32'h3CC);
    check(pwr_req[2] == 1'b0, "R12", "core2 untouched", 32'(pwr_req[2]), 32'd0);
  endtask

  task automatic t_ignore_busy();
    bit e, b; int c;
    run_cmd(1'b1, 4'b0100, 3, e, c, b);
    check(!e, "R5", "enable core2", 32'(e), 32'd0);
    check(pwr_req == 4'b0111 && core_stall == 4'b1000, "R11",
          "disable while busy ignored", {pwr_req, core_stall}, 32'h78);
  endtask

  task automatic t_already_on();
    bit e, b; int c;
    run_cmd(1'b1, 4'b0011, 0, e, c, b);
    check(c == 1 && !e, "R3", "already enabled completes at once", 32'(c), 32'd1);
    check(core_stall == 4'b1000, "R3", "outputs kept", 32'(core_stall), 32'h8);
  endtask

  task automatic t_disable_one();
    bit e, b; int c;
    run_cmd(1'b0, 4'b0001, 0, e, c, b);
    check(!e, "R9", "disable err", 32'(e), 32'd0);
    check(!pwr_req[0] && core_rst[0] && core_stall[0], "R9", "core0 off",
          {pwr_req[0], core_rst[0], core_stall[0]}, 32'h3);
    check(pwr_req[1] && !core_stall[1], "R12", "core1 still on",
          {pwr_req[1], core_stall[1]}, 32'h2);
  endtask

  task automatic t_pwrdn_timeout();
    bit e, b; int c;
    f_stuck[1] = 1'b1;
    run_cmd(1'b0, 4'b0010, 0, e, c, b);
    check(e, "R10", "power-down timeout err", 32'(e), 32'd1);
    check(c >= T_DN, "R10", "power-down limit", 32'(c), 32'(T_DN));
    f_stuck[1] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_pwrup_timeout();
    bit e, b; int c;
    f_noack[0] = 1'b1;
    run_cmd(1'b1, 4'b0001, 0, e, c, b);
    check(e, "R6", "power-up timeout err", 32'(e), 32'd1);
    check(c >= T_UP && c < T_DN, "R6", "power-up limit", 32'(c), 32'(T_UP));
    check(core_rst[0] && core_stall[0], "R6", "core0 held",
          {core_rst[0], core_stall[0]}, 32'h3);
    f_noack[0] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_rst_timeout();
    bit e, b; int c;
    f_rststuck[1] = 1'b1;
    run_cmd(1'b1, 4'b0010, 0, e, c, b);
    check(e, "R7", "reset timeout err", 32'(e), 32'd1);
    check(core_stall[1], "R7", "core1 stalled", 32'(core_stall[1]), 32'd1);
    f_rststuck[1] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_verify_fail();
    bit e, b; int c;
    f_rerst[0] = 1'b1;
    run_cmd(1'b1, 4'b0001, 0, e, c, b);
    check(e, "R8", "post-unstall check err", 32'(e), 32'd1);
    check(core_rst[0] && core_stall[0], "R8", "rollback to stall+reset",
          {core_rst[0], core_stall[0]}, 32'h3);
    f_rerst[0] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_full_cycle();
    bit e, b; int c;
    run_cmd(1'b1, 4'b1111, 0, e, c, b);
    check(!e && pwr_req == 4'b0111 && core_rst == 4'b1000 && core_stall == 4'b1000,
          "R5", "three cores up", {e, pwr_req, core_rst, core_stall}, 32'h788);
    run_cmd(1'b0, 4'b1111, 0, e, c, b);
    check(!e && pwr_req == '0 && core_rst == '1 && core_stall == '1,
          "R9", "all down", {e, pwr_req, core_rst, core_stall}, 32'h0FF);
  endtask

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_filtered_empty();
    t_enable_pair();
    t_ignore_busy();
    t_already_on();
    t_disable_one();
    t_pwrdn_timeout();
    t_pwrup_timeout();
    t_rst_timeout();
    t_verify_fail();
    t_full_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule